// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

This block tests the bit error rate of one serial port. A pseudo-random generator based on x^15 + x^14 + 1 drives the transmit bit. A matching checker on the receive bit synchronises itself to the incoming stream and then counts every bit that departs from the predicted sequence. Transmit and receive each have their own enable bit. The enables step only on cycles where the bit-rate strobe `bitEn` is high.

Software drives a small control register. Rising edges of two of its bits start actions: one reloads the generator, the other zeroes the error counter. A read-only lock flag in the same register reports synchronisation. The flag stays set until receive is enabled afresh. The error count that software reads is a snapshot of the internal counter, taken at each frame boundary (`frameTick`), so it does not change between frames.

Top module: `prbs_bert`

## Requirements
- R1: After reset, the control readback is 0, the error count register is 0 and `txBit` is 0.
- R2: Control layout: bit 0 enables transmit, bit 1 enables receive, bit 2 is the reseed bit, bit 3 is the clear bit, and bit 4 is the read-only lock flag. Writes to bit 4 are ignored. Bits 15:5 always read zero.
- R3: With transmit enabled, `txBit` follows y(n) = y(n-15) XOR y(n-14) and advances once per `bitEn` cycle. It holds while `bitEn` is low. It is 0 while transmit is disabled.
- R4: A 0-to-1 change of the reseed bit loads the all-ones seed on the following clock. The next 15 transmitted bits are therefore 1, and the 16th is 0.
- R5: After a rising edge of receive enable, lock is never declared within the first 15 received bits. Given a valid sequence, lock is declared within 31 bits (15 to fill history plus 16 consecutive matches).
- R6: The lock flag is sticky. Disabling receive does not clear it. Only a 0-to-1 change of receive enable clears it, on the following clock.
- R7: Once locked, each received bit that differs from the prediction adds exactly one to the internal counter. The checker then runs on its own prediction, so one flipped bit counts once.
- R8: The 16-bit error counter saturates at 0xFFFF and does not wrap.
- R9: The readable error count changes only at a `frameTick`, when it copies the internal counter.
- R10: A 0-to-1 change of the clear bit zeroes both the internal counter and the readable count on the following clock.
- R11: With receive disabled, received bits are neither checked nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit-rate strobe; one serial bit per high cycle |
| frameTick | input | 1 | Frame boundary pulse; snapshots the error count |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 16 | Control write data |
| ctrlRdData | output | 16 | Control readback, including the lock flag |
| errCount | output | 16 | Readable error count (frame snapshot) |
| txBit | output | 1 | Transmitted pseudo-random bit |
| rxBit | input | 1 | Received bit to check |

## Verification
The hardest state to reach from the ports is a saturated counter. The bench gets there by looping the transmit bit back inverted after lock. Because the locked checker runs on its own prediction, every inverted bit is an error, and about 65,540 bit times push the count past 0xFFFF. A second snapshot then shows that it does not wrap. The lock window is pinned from both sides: after the rising edge of receive enable, the bench counts exactly 15 and then 31 processed bits. Single flipped bits show that each error is counted once.

// File: rtl/bert_pkg.sv
package bert_pkg;
  // Control register bit positions
  localparam int BIT_TX    = 0;
  localparam int BIT_RX    = 1;
  localparam int BIT_SEED  = 2;
  localparam int BIT_CLR   = 3;
  localparam int BIT_LOCK  = 4;
  localparam int CTRL_BITS = 4;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic txEn;
    logic rxEn;
    logic reseed;
    logic clearCnt;
    logic rxStart;
  } bertStb_t;
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int SEQ_LEN = 15,
  parameter int TAP     = 14
) (
  input  logic clk,
  input  logic rstN,
  input  logic reseed,
  input  logic advance,
  output logic seqBit
);
  localparam logic [SEQ_LEN-1:0] SEED = '1;

  logic [SEQ_LEN-1:0] state;
  logic               feedback;

  assign feedback = state[SEQ_LEN-1] ^ state[TAP-1];
  assign seqBit   = state[SEQ_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN || reseed) begin
      state <= SEED;
    end else if (advance) begin
      state <= {state[SEQ_LEN-2:0], feedback};
    end
  end
endmodule

// File: rtl/bert_datapath.sv
module bert_datapath
  import bert_pkg::*;
#(
  parameter int SEQ_LEN  = 15,
  parameter int TAP      = 14,
  parameter int LOCK_RUN = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  bertStb_t         stb,
  input  logic             bitEn,
  input  logic             frameTick,
  input  logic             rxBit,
  output logic             txBit,
  output logic             locked,
  output logic [CNT_W-1:0] errCount
);
  localparam int               RUN_W    = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic               genBit;
  logic [SEQ_LEN-1:0] hist;
  logic [RUN_W-1:0]   runLen;
  logic [CNT_W-1:0]   errInt;
  logic               predicted;
  logic               mismatch;
  logic               rxStep;

  // Transmit side
  prbs_gen #(.SEQ_LEN(SEQ_LEN), .TAP(TAP)) uGen (
    .clk    (clk),
    .rstN   (rstN),
    .reseed (stb.reseed),
    .advance(stb.txEn & bitEn),
    .seqBit (genBit)
  );
  assign txBit = stb.txEn & genBit;

  // Receive side: self-synchronising predictor
  assign predicted = hist[SEQ_LEN-1] ^ hist[TAP-1];
  assign mismatch  = rxBit ^ predicted;
  assign rxStep    = stb.rxEn & bitEn & ~stb.rxStart;

  always_ff @(posedge clk) begin
    if (!rstN || stb.rxStart) begin
      hist   <= '0;
      runLen <= '0;
      locked <= 1'b0;
    end else if (rxStep) begin
      // Load from the line until lock, then free-run on the prediction
      hist <= {hist[SEQ_LEN-2:0], locked ? predicted : rxBit};
      if (!locked) begin
        if (mismatch) begin
          runLen <= '0;
        end else if (runLen == RUN_LAST) begin
          locked <= 1'b1;
        end else begin
          runLen <= runLen + 1'b1;
        end
      end
    end
  end

  // Internal counter and frame snapshot
  always_ff @(posedge clk) begin
    if (!rstN || stb.clearCnt) begin
      errInt <= '0;
    end else if (rxStep && locked && mismatch && errInt != CNT_MAX) begin
      errInt <= errInt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearCnt) begin
      errCount <= '0;
    end else if (frameTick) begin
      errCount <= errInt;
    end
  end
endmodule

// File: rtl/bert_ctrl.sv
module bert_ctrl
  import bert_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             lockIn,
  output logic [REG_W-1:0] rdData,
  output bertStb_t         stb
);
  logic [CTRL_BITS-1:0] ctrlReg;
  logic [CTRL_BITS-1:0] ctrlPrev;
  logic [CTRL_BITS-1:0] rise;
  logic                 unusedHiBits;

  // Upper write bits, including the read-only lock position, are discarded
  assign unusedHiBits = ^wdata[REG_W-1:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      ctrlPrev <= '0;
    end else begin
      ctrlPrev <= ctrlReg;
      if (we) ctrlReg <= wdata[CTRL_BITS-1:0];
    end
  end

  assign rise = ctrlReg & ~ctrlPrev;

  always_comb begin
    stb.txEn     = ctrlReg[BIT_TX];
    stb.rxEn     = ctrlReg[BIT_RX];
    stb.reseed   = rise[BIT_SEED];
    stb.clearCnt = rise[BIT_CLR];
    stb.rxStart  = rise[BIT_RX];
  end

  always_comb begin
    rdData                  = '0;
    rdData[CTRL_BITS-1:0]   = ctrlReg;
    rdData[BIT_LOCK]        = lockIn;
  end
endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
  import bert_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int SEQ_LEN  = 15,
  parameter int TAP      = 14,
  parameter int LOCK_RUN = 16,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             frameTick,
  input  logic             ctrlWe,
  input  logic [REG_W-1:0] ctrlWdata,
  output logic [REG_W-1:0] ctrlRdData,
  output logic [CNT_W-1:0] errCount,
  output logic             txBit,
  input  logic             rxBit
);
  bertStb_t ctrlStb;
  logic     lockFlag;

  bert_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .we    (ctrlWe),
    .wdata (ctrlWdata),
    .lockIn(lockFlag),
    .rdData(ctrlRdData),
    .stb   (ctrlStb)
  );

  bert_datapath #(
    .SEQ_LEN (SEQ_LEN),
    .TAP     (TAP),
    .LOCK_RUN(LOCK_RUN),
    .CNT_W   (CNT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .bitEn    (bitEn),
    .frameTick(frameTick),
    .rxBit    (rxBit),
    .txBit    (txBit),
    .locked   (lockFlag),
    .errCount (errCount)
  );
endmodule

// File: rtl/prbs_bert_chk.sv
module prbs_bert_chk #(
  parameter int REG_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameTick,
  input logic [REG_W-1:0] ctrlRdData,
  input logic [CNT_W-1:0] errCount,
  input logic             txBit,
  input logic             clearStb,
  input logic             rxStartStb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[REG_W-1:5] == '0);

  a_r3_tx_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[0] |-> !txBit);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData[4] && !rxStartStb) |=> ctrlRdData[4]);

  a_r6_lock_cleared: assert property (@(posedge clk) disable iff (!rstN)
    rxStartStb |=> !ctrlRdData[4]);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !clearStb) |=> errCount == CNT_MAX);

  a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (!rstN)
    (!frameTick && !clearStb) |=> $stable(errCount));

  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> errCount == '0);
endmodule

bind prbs_bert prbs_bert_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frameTick (frameTick),
  .ctrlRdData(ctrlRdData),
  .errCount  (errCount),
  .txBit     (txBit),
  .clearStb  (ctrlStb.clearCnt),
  .rxStartStb(ctrlStb.rxStart)
);

// File: tb/prbs_bert_test.sv
module prbs_bert_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        frameTick = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWdata = '0;
  logic [15:0] ctrlRdData;
  logic [15:0] errCount;
  logic        txBit;
  logic        flip = 1'b0;
  logic        rxBit;

  int nChecks = 0;
  int nErrors = 0;
  int seqExp [40];

  always #2 clk = ~clk; // 250 MHz

  assign rxBit = txBit ^ flip;

  prbs_bert uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameTick(frameTick),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdData(ctrlRdData),
    .errCount(errCount), .txBit(txBit), .rxBit(rxBit)
  );

  // {write value, expected readback} with lock clear
  localparam logic [31:0] CTRL_VEC [0:5] = '{
    32'hFFFF_000F, 32'h0000_0000, 32'h0010_0000,
    32'h0003_0003, 32'h8001_0001, 32'h0000_0000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [15:0] v);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    step(1);
    ctrlWe = 1'b0;
  endtask

  task automatic pulseFrame();
    frameTick = 1'b1;
    step(1);
    frameTick = 1'b0;
  endtask

  task automatic flipOne();
    flip = 1'b1;
    step(1);
    flip = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 40; n++)
      seqExp[n] = (n < 15) ? 1 : (seqExp[n-15] ^ seqExp[n-14]);

    @(negedge clk);
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check("R1 readback", 32'(ctrlRdData), 32'h0);
    check("R1 errCount", 32'(errCount), 32'h0);
    check("R1 txBit", 32'(txBit), 32'h0);

    // R2 control layout table
    for (int i = 0; i < 6; i++) begin
      writeCtrl(CTRL_VEC[i][31:16]);
      check("R2 readback", 32'(ctrlRdData), 32'(CTRL_VEC[i][15:0]));
    end

    // R3/R4 generator after reseed
    bitEn = 1'b1;
    writeCtrl(16'h0001);
    step(7);
    writeCtrl(16'h0005);
    step(1);
    for (int n = 0; n < 40; n++) begin
      check("R4/R3 txBit sequence", 32'(txBit), 32'(seqExp[n]));
      step(1);
    end
    writeCtrl(16'h0001);
    begin
      logic held;
      bitEn = 1'b0;
      held = txBit;
      step(5);
      check("R3 hold without bitEn", 32'(txBit), 32'(held));
      bitEn = 1'b1;
    end
    writeCtrl(16'h0000);
    step(3);
    check("R3 tx disabled", 32'(txBit), 32'h0);

    // R5 lock window
    writeCtrl(16'h0001);
    step(5);
    writeCtrl(16'h0003);
    step(1);
    step(15);
    check("R5 no lock at 15 bits", 32'(ctrlRdData[4]), 32'h0);
    step(16);
    check("R5 lock by 31 bits", 32'(ctrlRdData[4]), 32'h1);
    pulseFrame();
    check("R7 no errors on clean stream", 32'(errCount), 32'h0);

    // R7 single error, R9 snapshot timing
    flipOne();
    step(4);
    check("R9 count held before frame", 32'(errCount), 32'h0);
    pulseFrame();
    check("R7 single flip counts once", 32'(errCount), 32'h1);
    for (int k = 0; k < 3; k++) begin
      flipOne();
      step(20);
    end
    pulseFrame();
    check("R7 three more flips", 32'(errCount), 32'h4);

    // R11 / R6 receive disabled
    writeCtrl(16'h0001);
    flip = 1'b1;
    step(10);
    flip = 1'b0;
    pulseFrame();
    check("R11 no counting while rx off", 32'(errCount), 32'h4);
    check("R6 lock kept while rx off", 32'(ctrlRdData[4]), 32'h1);

    // R6 relock after rising receive enable
    writeCtrl(16'h0003);
    step(1);
    check("R6 lock cleared by rx rise", 32'(ctrlRdData[4]), 32'h0);
    step(31);
    check("R6 relocked", 32'(ctrlRdData[4]), 32'h1);
    pulseFrame();
    check("R7 no counting during acquisition", 32'(errCount), 32'h4);

    // R10 clear
    writeCtrl(16'h000B);
    step(1);
    check("R10 clear zeroes count", 32'(errCount), 32'h0);
    writeCtrl(16'h0003);
    pulseFrame();
    check("R10 internal counter zeroed", 32'(errCount), 32'h0);

    // R8 saturation
    flip = 1'b1;
    step(65540);
    pulseFrame();
    check("R8 saturated", 32'(errCount), 32'hFFFF);
    step(10);
    flip = 1'b0;
    pulseFrame();
    check("R8 no wrap", 32'(errCount), 32'hFFFF);
    writeCtrl(16'h000B);
    step(1);
    check("R10 clear after saturation", 32'(errCount), 32'h0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule